// File: doc/BRIEF.md
# FIR Multiply-Accumulate Engine with Hardware Loop

This block computes one output sample of a finite impulse response filter, `y = sum over i of x[n-1-i] * a[i]` for `i = 0 .. n-1`, where `n` is the tap count. It holds two operand registers and a wide accumulator. Two address pointers walk a coefficient memory upward and a sample memory downward. Both memories are external and have a synchronous read port.

A hardware loop controller runs the taps. In every loop cycle, one multiply-accumulate is performed, the operands for the next tap are fetched, both pointers are post-modified, and the loop counter is tested. No cycle is lost to a branch or to pointer arithmetic. An accepted start takes one setup cycle to preload the operands. After that, each tap costs exactly one cycle. A one-cycle done strobe marks the result, and the result then stays on the output until the next start.

Top module: `mac_zol_engine`

## Requirements
- R1: After reset, `done` is 0 and `acc_out` is 0.
- R2: For a tap count `n` from 1 to 2^TW-1, `acc_out` at the done strobe equals the sum over i = 0 .. n-1 of `x[n-1-i] * a[i]`. Here `x[k]` is the sample word at `samp_addr` k and `a[k]` is the coefficient word at `coef_addr` k. Both are DW-bit two's complement values, and the sum is a two's complement number.
- R3: The accumulator is 2*DW+TW bits wide. It gives the exact sum even when every tap is at the extreme value (-2^(DW-1) times -2^(DW-1), or -2^(DW-1) times 2^(DW-1)-1) and `n` is 2^TW-1.
- R4: `done` is high for exactly one cycle. It rises in the (n+2)-th cycle after the clock edge that accepted `start`: one setup cycle, n tap cycles, then the strobe.
- R5: An accepted start clears the accumulator, so `acc_out` reads 0 in the cycle after the accepting edge.
- R6: While idle, `coef_addr` shows 0 and `samp_addr` shows `taps-1`. From the first cycle after an accepted start until the end of the run, `coef_addr` rises by 1 each cycle and `samp_addr` falls by 1 each cycle (modulo 2^AW). The memory data for an address appears one cycle after that address.
- R7: A `start` that arrives while a run is in progress is ignored. The running computation's result and its done timing are unchanged.
- R8: Between the done strobe and the next accepted start, `acc_out` holds its value and `done` stays 0. This holds even when `taps` changes.
- R9: A tap count of 0 gives `acc_out` = 0, with `done` two cycles after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request a new output sample; taken only when idle |
| taps | input | TW | Tap count n, sampled with an accepted start |
| coef_addr | output | AW | Coefficient memory read address |
| coef_rdata | input | DW | Coefficient read data, one cycle after its address |
| samp_addr | output | AW | Sample memory read address |
| samp_rdata | input | DW | Sample read data, one cycle after its address |
| done | output | 1 | One-cycle strobe when the result is ready |
| acc_out | output | 2*DW+TW | Accumulator value |

## Verification
The engine is run with ramps of mixed sign, with a single tap, and with two taps. The two-tap case shows whether the samples are paired with the coefficients in reversed order, because a reversed pairing gives a different sum. Full-length runs with every word at the most negative value, and then paired with the most positive value, show whether the sign extension and the accumulator width are correct. A zero tap count checks the shortcut out of the setup cycle. A start injected in mid-run, and idle cycles with a changing tap count, check that a busy engine is not disturbed and that the held result is not disturbed.

// File: rtl/mac_zol_pkg.sv
// Shared definitions for the FIR multiply-accumulate engine.
// Assumes: nothing beyond IEEE 1800-2017.
package mac_zol_pkg;

    // Engine phases: idle, operand preload, tap loop.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOAD = 2'd1,
        PH_RUN  = 2'd2
    } phase_e;

    // Accumulator width: full product plus one guard bit per doubling of taps.
    function automatic int acc_width(input int dw, input int tw);
        return 2 * dw + tw;
    endfunction

endpackage

// File: rtl/mac_zol_loop_ctrl.sv
// Hardware loop controller.
// Accepts a start only when idle and latches the tap count. It spends one
// preload cycle, then counts one iteration per cycle and ends the loop in
// the same cycle as the final multiply-accumulate, raising done for one cycle.
// Assumes: taps is stable only at the accepting edge; a count of 0 skips the loop.
module mac_zol_loop_ctrl
    import mac_zol_pkg::*;
#(
    parameter int TW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [TW-1:0] taps,
    output phase_e        phase,
    output logic          accept,
    output logic          fetch_adv,
    output logic          mac_en,
    output logic          done
);

    logic [TW-1:0] taps_q;
    logic [TW-1:0] iter;
    logic          last_iter;

    // Decode the phase into the per-cycle strobes used by the datapath.
    always_comb begin
        accept    = start && (phase == PH_IDLE);
        fetch_adv = (phase != PH_IDLE);
        mac_en    = (phase == PH_RUN);
        last_iter = (phase == PH_RUN) && (iter == taps_q - TW'(1));
    end

    // Phase register, iteration counter and end-of-loop test.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_IDLE;
            taps_q <= '0;
            iter   <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        taps_q <= taps;
                        iter   <= '0;
                        phase  <= PH_LOAD;
                    end
                end
                PH_LOAD: begin
                    if (taps_q == '0) begin
                        phase <= PH_IDLE;
                        done  <= 1'b1;
                    end else begin
                        phase <= PH_RUN;
                    end
                end
                PH_RUN: begin
                    if (last_iter) begin
                        phase <= PH_IDLE;
                        done  <= 1'b1;
                    end else begin
                        iter <= iter + TW'(1);
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/mac_zol_agu.sv
// Address generator for one pointer with post-modify by a fixed step.
// While idle, the preset address is presented directly so that the memory
// starts its first read at the accepting edge. The pointer register is then
// loaded with the preset plus one step and advances one step per busy cycle.
// Assumes: load and adv are never active together; addresses wrap modulo 2^AW.
module mac_zol_agu #(
    parameter int AW      = 8,
    parameter bit STEP_UP = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          idle,
    input  logic [AW-1:0] preset,
    input  logic          load,
    input  logic          adv,
    output logic [AW-1:0] addr
);

    logic [AW-1:0] ptr;
    logic [AW-1:0] base;
    logic [AW-1:0] stepped;

    // Pick the value to modify: the preset on load, otherwise the pointer.
    always_comb base = load ? preset : ptr;

    // The step direction is fixed per instance.
    generate
        if (STEP_UP) begin : g_inc
            always_comb stepped = base + AW'(1);
        end else begin : g_dec
            always_comb stepped = base - AW'(1);
        end
    endgenerate

    // Pointer register with post-modify.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (load || adv) begin
            ptr <= stepped;
        end
    end

    // Present the preset while idle, otherwise the live pointer.
    always_comb addr = idle ? preset : ptr;

endmodule

// File: rtl/mac_zol_mac.sv
// Multiply-accumulate datapath: two operand registers and a wide accumulator.
// The operand registers capture memory read data on every busy cycle. The
// accumulator adds the signed product of the current operands while in the
// loop, and it is cleared on an accepted start.
// Assumes: clr never coincides with mac_en.
module mac_zol_mac #(
    parameter int DW = 16,
    parameter int TW = 6
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clr,
    input  logic                        capture,
    input  logic                        mac_en,
    input  logic signed [DW-1:0]        x_in,
    input  logic signed [DW-1:0]        a_in,
    output logic signed [2*DW+TW-1:0]   acc
);

    localparam int PW   = 2 * DW;
    localparam int ACCW = PW + TW;

    logic signed [DW-1:0]   op_x;
    logic signed [DW-1:0]   op_a;
    logic signed [PW-1:0]   prod;
    logic signed [ACCW-1:0] prod_ext;

    // Signed product, sign-extended to the accumulator width.
    always_comb begin
        prod     = op_x * op_a;
        prod_ext = {{TW{prod[PW-1]}}, prod};
    end

    // Operand registers follow the memory read ports during a run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_x <= '0;
            op_a <= '0;
        end else if (capture) begin
            op_x <= x_in;
            op_a <= a_in;
        end
    end

    // Accumulator: clear on start, add the product in each loop cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (clr) begin
            acc <= '0;
        end else if (mac_en) begin
            acc <= acc + prod_ext;
        end
    end

endmodule

// File: rtl/mac_zol_engine.sv
// FIR multiply-accumulate engine with a hardware loop.
// It computes y = sum x[n-1-i]*a[i] at one tap per cycle after a single
// preload cycle. The coefficient pointer steps up from 0 and the sample
// pointer steps down from n-1.
// Assumes: both memories return data one cycle after the address; AW >= TW.
module mac_zol_engine
    import mac_zol_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 8,
    parameter int TW = 6,
    localparam int ACCW = 2 * DW + TW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [TW-1:0]   taps,
    output logic [AW-1:0]   coef_addr,
    input  logic [DW-1:0]   coef_rdata,
    output logic [AW-1:0]   samp_addr,
    input  logic [DW-1:0]   samp_rdata,
    output logic            done,
    output logic [ACCW-1:0] acc_out
);

    phase_e                 phase;
    logic                   accept;
    logic                   fetch_adv;
    logic                   mac_en;
    logic                   idle;
    logic [AW-1:0]          samp_preset;
    logic signed [ACCW-1:0] acc;

    // Derived controls and preset addresses.
    always_comb begin
        idle        = (phase == PH_IDLE);
        samp_preset = AW'(taps) - AW'(1);
        acc_out     = acc;
    end

    mac_zol_loop_ctrl #(.TW(TW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .taps      (taps),
        .phase     (phase),
        .accept    (accept),
        .fetch_adv (fetch_adv),
        .mac_en    (mac_en),
        .done      (done)
    );

    mac_zol_agu #(.AW(AW), .STEP_UP(1'b1)) u_agu_coef (
        .clk    (clk),
        .rst_n  (rst_n),
        .idle   (idle),
        .preset ('0),
        .load   (accept),
        .adv    (fetch_adv),
        .addr   (coef_addr)
    );

    mac_zol_agu #(.AW(AW), .STEP_UP(1'b0)) u_agu_samp (
        .clk    (clk),
        .rst_n  (rst_n),
        .idle   (idle),
        .preset (samp_preset),
        .load   (accept),
        .adv    (fetch_adv),
        .addr   (samp_addr)
    );

    mac_zol_mac #(.DW(DW), .TW(TW)) u_mac (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (accept),
        .capture (fetch_adv),
        .mac_en  (mac_en),
        .x_in    (samp_rdata),
        .a_in    (coef_rdata),
        .acc     (acc)
    );

endmodule

// File: rtl/mac_zol_checker.sv
// Protocol checker for the FIR engine, attached by bind.
// Observes ports and the controller phase; drives nothing.
module mac_zol_checker
    import mac_zol_pkg::*;
#(
    parameter int AW   = 8,
    parameter int ACCW = 38
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic            done,
    input logic [ACCW-1:0] acc_out,
    input logic [AW-1:0]   coef_addr,
    input logic [AW-1:0]   samp_addr,
    input phase_e          phase
);

    // R4: the strobe lasts a single cycle.
    a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4: a strobe only follows the preload or the loop.
    a_r4_done_origin: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(phase) == PH_RUN || $past(phase) == PH_LOAD));

    // R5: an accepted start clears the accumulator.
    a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && start) |=> (acc_out == '0));

    // R8: an idle engine without start keeps its result.
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && !start) |=> $stable(acc_out));

    // R7: a busy engine never re-enters the preload.
    a_r7_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_IDLE) |=> (phase != PH_LOAD));

    // R6: pointers post-modify by one step each busy cycle.
    a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_IDLE) |=> (phase == PH_IDLE) ||
            (coef_addr == $past(coef_addr) + AW'(1) &&
             samp_addr == $past(samp_addr) - AW'(1)));

endmodule

bind mac_zol_engine mac_zol_checker #(.AW(AW), .ACCW(ACCW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .done      (done),
    .acc_out   (acc_out),
    .coef_addr (coef_addr),
    .samp_addr (samp_addr),
    .phase     (phase)
);

// File: tb/sim_mac_zol_engine.sv
// Directed bench for the FIR engine: one task per scenario.
module sim_mac_zol_engine;

    localparam int CLK_PERIOD = 10;
    localparam int DW   = 16;
    localparam int AW   = 8;
    localparam int TW   = 6;
    localparam int ACCW = 2 * DW + TW;
    localparam int MEMD = 1 << AW;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [TW-1:0]   taps = '0;
    logic [AW-1:0]   coef_addr;
    logic [DW-1:0]   coef_rdata;
    logic [AW-1:0]   samp_addr;
    logic [DW-1:0]   samp_rdata;
    logic            done;
    logic [ACCW-1:0] acc_out;

    logic signed [DW-1:0] cmem [MEMD];
    logic signed [DW-1:0] smem [MEMD];

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mac_zol_engine #(.DW(DW), .AW(AW), .TW(TW)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .taps       (taps),
        .coef_addr  (coef_addr),
        .coef_rdata (coef_rdata),
        .samp_addr  (samp_addr),
        .samp_rdata (samp_rdata),
        .done       (done),
        .acc_out    (acc_out)
    );

    // Synchronous-read memory models, one cycle of latency.
    always @(posedge clk) begin
        coef_rdata <= cmem[coef_addr];
        samp_rdata <= smem[samp_addr];
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint ref_y(input int n);
        longint s = 0;
        for (int i = 0; i < n; i++)
            s += longint'(smem[(n - 1 - i) % MEMD]) * longint'(cmem[i % MEMD]);
        return s;
    endfunction

    function automatic longint acc_val();
        return longint'($signed(acc_out));
    endfunction

    // Run one output sample; optionally inject a start mid-run at cycle intr_at.
    task automatic run_fir(input int n, input string req, input int intr_at);
        int k;
        longint exp;
        exp = ref_y(n);
        @(negedge clk);
        taps  = TW'(n);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        k = 1;
        check(acc_val() == 0, "R5 clear on start", acc_val(), 0);
        if (n >= 2) begin
            check(int'(coef_addr) == 1, "R6 coef pointer after start", coef_addr, 1);
            check(int'(samp_addr) == n - 2, "R6 sample pointer after start", samp_addr, n - 2);
        end
        while (!done && k < 200) begin
            @(posedge clk);
            @(negedge clk);
            k++;
            start = (k == intr_at);
            if (k == intr_at) taps = TW'(3);
        end
        start = 1'b0;
        check(k == n + 2, {req, " R4 done latency"}, k, n + 2);
        check(acc_val() == exp, {req, " result"}, acc_val(), exp);
        @(posedge clk);
        @(negedge clk);
        check(done == 1'b0, "R4 single-cycle done", done, 0);
    endtask

    task automatic test_reset();
        check(done == 1'b0, "R1 done after reset", done, 0);
        check(acc_val() == 0, "R1 acc after reset", acc_val(), 0);
    endtask

    task automatic fill_ramp();
        for (int i = 0; i < MEMD; i++) begin
            smem[i] = DW'(i * 37 - 500);
            cmem[i] = DW'(((i * 13) % 29) - 14);
        end
    endtask

    task automatic fill_const(input int xv, input int av);
        for (int i = 0; i < MEMD; i++) begin
            smem[i] = DW'(xv);
            cmem[i] = DW'(av);
        end
    endtask

    task automatic test_basic();
        fill_ramp();
        run_fir(1, "R2 one tap", -1);
        run_fir(2, "R2 two taps reversed pairing", -1);
        run_fir(8, "R2 eight taps mixed sign", -1);
        run_fir(21, "R2 twenty-one taps", -1);
    endtask

    task automatic test_extremes();
        fill_const(-32768, -32768);
        run_fir(63, "R3 max positive sum", -1);
        fill_const(-32768, 32767);
        run_fir(63, "R3 max negative sum", -1);
    endtask

    task automatic test_zero_taps();
        fill_ramp();
        run_fir(5, "R2 prior result", -1);
        run_fir(0, "R9 zero taps", -1);
    endtask

    task automatic test_busy_start();
        fill_ramp();
        run_fir(10, "R7 start while busy", 4);
    endtask

    task automatic test_hold();
        longint held;
        fill_ramp();
        run_fir(6, "R8 setup", -1);
        held = acc_val();
        for (int c = 0; c < 5; c++) begin
            @(negedge clk);
            taps = TW'(c + 9);
        end
        @(negedge clk);
        check(acc_val() == held, "R8 acc held while idle", acc_val(), held);
        check(done == 1'b0, "R8 done low while idle", done, 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    // Main sequence.
    initial begin
        fill_ramp();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_basic();
        test_extremes();
        test_zero_taps();
        test_busy_start();
        test_hold();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule